// File: doc/BRIEF.md
# Hypervisor Virtual-Instruction Trap Classifier

This block sits at the trap-decision point of a core that supports hardware virtualization. For every instruction presented with a valid strobe, it decides whether the instruction retires cleanly, raises an illegal-instruction exception (cause 2) or raises a virtual-instruction exception (cause 22). The virtual-instruction exception marks cases the hypervisor is expected to emulate for a guest. The decision uses the virtualization bit, the current privilege level, the two counter-enable registers and the two hypervisor trap-control bits. For each trap it also reports the faulting instruction word as the trap value.

Wait-for-interrupt (WFI) instructions are handled by a bounded wait timer. A WFI starts a wait that ends quietly when an interrupt becomes pending. A guest whose wait reaches the configured cycle limit receives a virtual-instruction exception, so the hypervisor can reschedule. The decoder in front of the block supplies one-hot class flags. Delegation of the trap to a handler level is done downstream.

Top module: `hvi_trap_classifier`

## Requirements
- R1: Out of reset, `trap_valid`, `trap_cause` and `trap_val` are zero. The verdict for an instruction strobed on `instr_valid` at one rising edge appears on the outputs after that same edge and stays for one cycle only. Privilege encoding: `priv` 2'b00 is user, 2'b01 is supervisor and 2'b11 is machine.
- R2: Counter CSR access (`is_ctr`). The bit at index `ctr_idx` is looked up in `mcounteren` and in `hcounteren`. In machine mode the access never traps. In any other mode, a clear `mcounteren` bit gives cause 2. Otherwise, with the effective virtualization bit at 1, a clear `hcounteren` bit gives cause 22. In all remaining cases there is no trap.
- R3: Hypervisor load/store instructions (`is_hlv`, `is_hlvx`, `is_hsv`). With the effective virtualization bit at 1 they give cause 22. In non-virtualized user mode they give cause 2. In non-virtualized supervisor mode and in machine mode there is no trap.
- R4: Hypervisor fence (`is_hfence`) and hypervisor or guest-supervisor CSR access (`is_hcsr`). In user mode, virtualized or not, they give cause 2. In virtualized supervisor mode they give cause 22. Otherwise there is no trap.
- R5: Supervisor return (`is_sret`). In user mode it gives cause 2. In virtualized supervisor mode with `trap_sret` at 1 it gives cause 22. Otherwise there is no trap.
- R6: Supervisor fence (`is_sfence`) and address-translation register access (`is_satp`). In user mode they give cause 2. In virtualized supervisor mode with `trap_vm` at 1 they give cause 22. Otherwise there is no trap.
- R7: Both causes carry the full instruction word on `trap_val`. When `trap_valid` is 0, `trap_cause` and `trap_val` are 0.
- R8: At most one trap is reported per instruction. If several flags are set and any of them calls for cause 2, the cause is 2.
- R9: A WFI (`is_wfi`) never traps at issue. It starts a wait that lasts until an interrupt is pending or another instruction is strobed. If the WFI was issued with the effective virtualization bit at 1 and no interrupt is pending, `trap_valid` rises exactly `WFI_LIMIT` cycles after the issue edge. The trap has cause 22 and the WFI word as trap value, and the wait then ends. `wfi_waiting` is 1 while a wait is in progress.
- R10: An interrupt that is pending while a wait is in progress ends the wait at that edge. No trap follows.
- R11: A WFI issued with the effective virtualization bit at 0 waits without limit and never traps.
- R12: In machine mode the virtualization bit is ignored: the effective virtualization bit is `virt` AND NOT machine mode. No instruction class traps in machine mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction presented for a verdict this cycle |
| virt | input | 1 | Virtualization bit |
| priv | input | 2 | Privilege level (00 U, 01 S, 11 M) |
| is_ctr | input | 1 | Counter CSR access |
| is_wfi | input | 1 | Wait-for-interrupt |
| is_hlv | input | 1 | Hypervisor virtual-machine load |
| is_hlvx | input | 1 | Hypervisor virtual-machine load, execute permission |
| is_hsv | input | 1 | Hypervisor virtual-machine store |
| is_hfence | input | 1 | Hypervisor fence |
| is_hcsr | input | 1 | Hypervisor or guest-supervisor CSR access |
| is_sret | input | 1 | Supervisor return |
| is_sfence | input | 1 | Supervisor fence |
| is_satp | input | 1 | Address-translation register access |
| ctr_idx | input | IDX_W (5) | Counter index |
| mcounteren | input | NCTR (32) | Machine counter-enable register |
| hcounteren | input | NCTR (32) | Hypervisor counter-enable register |
| trap_sret | input | 1 | Trap guest supervisor return |
| trap_vm | input | 1 | Trap guest fence and translation register access |
| irq_pending | input | 1 | An interrupt is pending |
| instr | input | XLEN (32) | Instruction word |
| trap_valid | output | 1 | Trap reported this cycle |
| trap_cause | output | 5 | Exception cause (2 or 22) |
| trap_val | output | XLEN (32) | Trap value (faulting instruction) |
| wfi_waiting | output | 1 | A WFI wait is in progress |

## Verification
Immediate verdicts are due one cycle after the strobe. The bench records the strobe at the rising edge and compares the scoreboard entry at the following falling edge, so every check reads the register filled by that edge. The WFI timeout is due `WFI_LIMIT` edges after the issue edge. The bench counts falling edges from issue, requires silence on every one before that point, requires the trap exactly at that point, and requires a clear output one cycle later. Interrupt cancellation is checked on the edge after the interrupt is raised, and the outputs are then watched for twice the limit.

// File: rtl/hvi_pkg.sv
// Shared types and constants for the virtual-instruction trap classifier.
// Assumes a 5-bit exception cause field.
package hvi_pkg;
    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT    = 5'd22;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    // Verdict of one classification path.
    typedef struct packed {
        logic illegal;
        logic virt;
    } verdict_t;
endpackage

// File: rtl/hvi_ctr_check.sv
// Counter-enable check. The counter bit is looked up in both enable
// registers. A clear machine bit is illegal outside machine mode. A set
// machine bit with a clear hypervisor bit is virtual when virtualized.
// Assumes ctr_idx is below NCTR.
module hvi_ctr_check #(
    parameter int NCTR  = 32,
    parameter int IDX_W = $clog2(NCTR)
) (
    input  logic             is_ctr,
    input  logic             eff_v,
    input  logic             m_mode,
    input  logic [IDX_W-1:0] ctr_idx,
    input  logic [NCTR-1:0]  mcounteren,
    input  logic [NCTR-1:0]  hcounteren,
    output hvi_pkg::verdict_t verdict
);
    logic m_bit;
    logic h_bit;

    // Select the enable bits for the addressed counter.
    always_comb begin
        m_bit = mcounteren[ctr_idx];
        h_bit = hcounteren[ctr_idx];
    end

    // Form the counter verdict.
    always_comb begin
        verdict.illegal = is_ctr && !m_mode && !m_bit;
        verdict.virt    = is_ctr && !m_mode && m_bit && eff_v && !h_bit;
    end
endmodule

// File: rtl/hvi_classify.sv
// Combinational classifier for the non-WFI instruction classes. It
// produces separate illegal and virtual indications. Priority between
// the two is applied by the caller. Assumes eff_v is already forced to 0
// in machine mode.
module hvi_classify (
    input  logic       eff_v,
    input  logic [1:0] priv,
    input  logic       is_hlv,
    input  logic       is_hlvx,
    input  logic       is_hsv,
    input  logic       is_hfence,
    input  logic       is_hcsr,
    input  logic       is_sret,
    input  logic       is_sfence,
    input  logic       is_satp,
    input  logic       trap_sret,
    input  logic       trap_vm,
    input  hvi_pkg::verdict_t ctr_verdict,
    output hvi_pkg::verdict_t verdict
);
    import hvi_pkg::*;

    logic u_mode;
    logic vs_mode;
    logic hyp_ls;
    logic hyp_sys;
    logic vm_ops;

    // Decode the mode and group the instruction classes.
    always_comb begin
        u_mode  = (priv == PRIV_U);
        vs_mode = eff_v && (priv == PRIV_S);
        hyp_ls  = is_hlv || is_hlvx || is_hsv;
        hyp_sys = is_hfence || is_hcsr;
        vm_ops  = is_sfence || is_satp;
    end

    // Combine the per-class illegal and virtual conditions.
    always_comb begin
        verdict.illegal = ctr_verdict.illegal
                        || (hyp_ls && !eff_v && u_mode)
                        || (hyp_sys && u_mode)
                        || (is_sret && u_mode)
                        || (vm_ops && u_mode);
        verdict.virt    = ctr_verdict.virt
                        || (hyp_ls && eff_v)
                        || (hyp_sys && vs_mode)
                        || (is_sret && vs_mode && trap_sret)
                        || (vm_ops && vs_mode && trap_vm);
    end
endmodule

// File: rtl/hvi_wfi_timer.sv
// Bounded WFI wait timer. The wait starts on a strobed WFI. A pending
// interrupt or any other strobed instruction ends it. A virtualized wait
// that reaches WFI_LIMIT cycles raises a one-cycle timeout and ends. A
// non-virtualized wait holds at the limit.
// Assumes WFI_LIMIT >= 1.
module hvi_wfi_timer #(
    parameter int XLEN      = 32,
    parameter int WFI_LIMIT = 8,
    localparam int CNT_W    = (WFI_LIMIT > 1) ? $clog2(WFI_LIMIT) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic            is_wfi,
    input  logic            eff_v,
    input  logic            irq_pending,
    input  logic [XLEN-1:0] instr,
    output logic            waiting,
    output logic            timeout,
    output logic [XLEN-1:0] wfi_word
);
    logic [CNT_W-1:0] cnt;
    logic             virt_q;
    logic             at_lim;

    // Detect the final cycle of the wait window.
    always_comb at_lim = (cnt == CNT_W'(WFI_LIMIT - 1));

    // Raise the timeout when a virtualized wait is still running at the limit.
    always_comb timeout = waiting && !instr_valid && !irq_pending && at_lim && virt_q;

    // Sequence the wait: start, cancel, count and expire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting  <= 1'b0;
            cnt      <= '0;
            virt_q   <= 1'b0;
            wfi_word <= '0;
        end else if (instr_valid && is_wfi) begin
            waiting  <= 1'b1;
            cnt      <= '0;
            virt_q   <= eff_v;
            wfi_word <= instr;
        end else if (instr_valid || (waiting && irq_pending)) begin
            waiting  <= 1'b0;
        end else if (waiting) begin
            if (at_lim) begin
                if (virt_q) waiting <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hvi_trap_classifier.sv
// Top of the trap classifier. It derives the effective virtualization
// bit, merges the counter and class verdicts with illegal taking
// priority, and registers one verdict per strobed instruction or WFI
// timeout. Assumes the class flags come from a decoder, normally one-hot.
module hvi_trap_classifier #(
    parameter int XLEN      = 32,
    parameter int NCTR      = 32,
    parameter int WFI_LIMIT = 8,
    localparam int IDX_W    = $clog2(NCTR)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        instr_valid,
    input  logic                        virt,
    input  logic [1:0]                  priv,
    input  logic                        is_ctr,
    input  logic                        is_wfi,
    input  logic                        is_hlv,
    input  logic                        is_hlvx,
    input  logic                        is_hsv,
    input  logic                        is_hfence,
    input  logic                        is_hcsr,
    input  logic                        is_sret,
    input  logic                        is_sfence,
    input  logic                        is_satp,
    input  logic [IDX_W-1:0]            ctr_idx,
    input  logic [NCTR-1:0]             mcounteren,
    input  logic [NCTR-1:0]             hcounteren,
    input  logic                        trap_sret,
    input  logic                        trap_vm,
    input  logic                        irq_pending,
    input  logic [XLEN-1:0]             instr,
    output logic                        trap_valid,
    output logic [hvi_pkg::CAUSE_W-1:0] trap_cause,
    output logic [XLEN-1:0]             trap_val,
    output logic                        wfi_waiting
);
    import hvi_pkg::*;

    logic            m_mode;
    logic            eff_v;
    verdict_t        ctr_v;
    verdict_t        cls_v;
    logic            wfi_timeout;
    logic [XLEN-1:0] wfi_word;

    // Ignore the virtualization bit in machine mode.
    always_comb begin
        m_mode = (priv == PRIV_M);
        eff_v  = virt && !m_mode;
    end

    hvi_ctr_check #(.NCTR(NCTR), .IDX_W(IDX_W)) u_ctr (
        .is_ctr     (is_ctr),
        .eff_v      (eff_v),
        .m_mode     (m_mode),
        .ctr_idx    (ctr_idx),
        .mcounteren (mcounteren),
        .hcounteren (hcounteren),
        .verdict    (ctr_v)
    );

    hvi_classify u_cls (
        .eff_v       (eff_v),
        .priv        (priv),
        .is_hlv      (is_hlv),
        .is_hlvx     (is_hlvx),
        .is_hsv      (is_hsv),
        .is_hfence   (is_hfence),
        .is_hcsr     (is_hcsr),
        .is_sret     (is_sret),
        .is_sfence   (is_sfence),
        .is_satp     (is_satp),
        .trap_sret   (trap_sret),
        .trap_vm     (trap_vm),
        .ctr_verdict (ctr_v),
        .verdict     (cls_v)
    );

    hvi_wfi_timer #(.XLEN(XLEN), .WFI_LIMIT(WFI_LIMIT)) u_wfi (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .is_wfi      (is_wfi),
        .eff_v       (eff_v),
        .irq_pending (irq_pending),
        .instr       (instr),
        .waiting     (wfi_waiting),
        .timeout     (wfi_timeout),
        .wfi_word    (wfi_word)
    );

    // Register the single verdict for this cycle, illegal before virtual.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid <= 1'b0;
            trap_cause <= CAUSE_NONE;
            trap_val   <= '0;
        end else if (instr_valid) begin
            trap_valid <= cls_v.illegal || cls_v.virt;
            trap_cause <= cls_v.illegal ? CAUSE_ILLEGAL :
                          (cls_v.virt ? CAUSE_VIRT : CAUSE_NONE);
            trap_val   <= (cls_v.illegal || cls_v.virt) ? instr : '0;
        end else if (wfi_timeout) begin
            trap_valid <= 1'b1;
            trap_cause <= CAUSE_VIRT;
            trap_val   <= wfi_word;
        end else begin
            trap_valid <= 1'b0;
            trap_cause <= CAUSE_NONE;
            trap_val   <= '0;
        end
    end
endmodule

// File: rtl/hvi_trap_classifier_chk.sv
// Property checker for the trap classifier, attached by bind. It keeps
// its own count of cycles since the last strobed WFI to time the
// timeout window without deep $past.
module hvi_trap_classifier_chk #(
    parameter int XLEN      = 32,
    parameter int WFI_LIMIT = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic            virt,
    input logic [1:0]      priv,
    input logic            is_wfi,
    input logic            irq_pending,
    input logic [XLEN-1:0] instr,
    input logic            trap_valid,
    input logic [4:0]      trap_cause,
    input logic [XLEN-1:0] trap_val,
    input logic            wfi_waiting
);
    localparam int WC_W = $clog2(WFI_LIMIT + 3) + 1;
    logic [WC_W-1:0] wcnt;

    // Count edges since the last strobed WFI, saturating past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wcnt <= '0;
        else if (instr_valid)
            wcnt <= is_wfi ? WC_W'(1) : '0;
        else if (wcnt != '0 && wcnt < WC_W'(WFI_LIMIT + 2))
            wcnt <= wcnt + 1'b1;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !wfi_waiting) |=> !trap_valid);

    a_r7_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_cause == 5'd2 || trap_cause == 5'd22));

    a_r7_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_cause == 5'd0 && trap_val == '0));

    a_r7_tval_word: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> (!trap_valid || trap_val == $past(instr)));

    a_r12_mmode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && priv == 2'b11) |=> !trap_valid);

    a_r11_unvirt_no_22: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !virt) |=> !(trap_valid && trap_cause == 5'd22));

    a_r10_irq_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (wfi_waiting && irq_pending && !instr_valid) |=> (!wfi_waiting && !trap_valid));

    a_r9_timeout_window: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !$past(instr_valid)) |-> (wcnt == WC_W'(WFI_LIMIT + 1)));
endmodule

bind hvi_trap_classifier hvi_trap_classifier_chk #(
    .XLEN(XLEN), .WFI_LIMIT(WFI_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .virt        (virt),
    .priv        (priv),
    .is_wfi      (is_wfi),
    .irq_pending (irq_pending),
    .instr       (instr),
    .trap_valid  (trap_valid),
    .trap_cause  (trap_cause),
    .trap_val    (trap_val),
    .wfi_waiting (wfi_waiting)
);

// File: tb/hvi_trap_classifier_tb.sv
// Scoreboard bench: the driver pushes expected verdicts, and a monitor
// compares them one cycle after each strobe.
module hvi_trap_classifier_tb;
    localparam int XLEN = 32;
    localparam int NCTR = 32;
    localparam int LIM  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            instr_valid = 0, virt = 0, trap_sret = 0, trap_vm = 0, irq_pending = 0;
    logic [1:0]      priv = 0;
    logic [8:0]      cls = 0;
    logic            is_wfi = 0;
    logic [4:0]      ctr_idx = 0;
    logic [NCTR-1:0] mcounteren = 0, hcounteren = 0;
    logic [XLEN-1:0] instr = 0;
    logic            trap_valid, wfi_waiting;
    logic [4:0]      trap_cause;
    logic [XLEN-1:0] trap_val;

    hvi_trap_classifier #(.XLEN(XLEN), .NCTR(NCTR), .WFI_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .virt(virt), .priv(priv),
        .is_ctr(cls[0]), .is_wfi(is_wfi), .is_hlv(cls[1]), .is_hlvx(cls[2]), .is_hsv(cls[3]),
        .is_hfence(cls[4]), .is_hcsr(cls[5]), .is_sret(cls[6]), .is_sfence(cls[7]),
        .is_satp(cls[8]), .ctr_idx(ctr_idx), .mcounteren(mcounteren), .hcounteren(hcounteren),
        .trap_sret(trap_sret), .trap_vm(trap_vm), .irq_pending(irq_pending), .instr(instr),
        .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_val(trap_val),
        .wfi_waiting(wfi_waiting)
    );

    typedef struct {
        logic [4:0]      cause;
        logic [XLEN-1:0] word;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    logic armed = 0;

    // Compare one value and log a failure line on mismatch.
    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference verdict derived from the requirements (class index 0..8).
    function automatic logic [4:0] ref_cause(input logic v, input logic [1:0] p, input int c,
                                            input logic ts, input logic tv,
                                            input logic mb, input logic hb);
        logic ev, u, vs;
        ev = v && (p != 2'b11);
        u  = (p == 2'b00);
        vs = ev && (p == 2'b01);
        case (c)
            0: return (p == 2'b11) ? 5'd0 : (!mb ? 5'd2 : ((ev && !hb) ? 5'd22 : 5'd0));
            1, 2, 3: return ev ? 5'd22 : (u ? 5'd2 : 5'd0);
            4, 5: return u ? 5'd2 : (vs ? 5'd22 : 5'd0);
            6: return u ? 5'd2 : ((vs && ts) ? 5'd22 : 5'd0);
            default: return u ? 5'd2 : ((vs && tv) ? 5'd22 : 5'd0);
        endcase
    endfunction

    function automatic string class_tag(input int c, input logic [1:0] p);
        if (p == 2'b11) return "R12";
        case (c)
            0: return "R2";
            1, 2, 3: return "R3";
            4, 5: return "R4";
            6: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Driver: present one strobed instruction and push its expected verdict.
    task automatic issue(input logic [8:0] cv, input logic w, input logic v, input logic [1:0] p,
                         input logic ts, input logic tv, input logic [4:0] idx,
                         input logic [NCTR-1:0] me, input logic [NCTR-1:0] he,
                         input logic [XLEN-1:0] word, input logic [4:0] ecause, input string tag);
        exp_t e;
        @(negedge clk);
        cls = cv; is_wfi = w; virt = v; priv = p; trap_sret = ts; trap_vm = tv;
        ctr_idx = idx; mcounteren = me; hcounteren = he; instr = word; instr_valid = 1'b1;
        e.cause = ecause;
        e.word  = (ecause != 0) ? word : '0;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic go_idle();
        @(negedge clk);
        instr_valid = 1'b0; cls = '0; is_wfi = 1'b0;
    endtask

    // Monitor: note a strobe at the edge, compare at the following falling edge.
    always @(posedge clk) armed <= instr_valid && rst_n;

    always @(negedge clk) begin
        if (armed) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                check("R1 scoreboard empty", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check({e.tag, " valid"}, XLEN'(trap_valid), XLEN'(e.cause != 0));
                check({e.tag, " cause"}, XLEN'(trap_cause), XLEN'(e.cause));
                check({e.tag, " R7 trap_val"}, trap_val, e.word);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int n;
        logic [NCTR-1:0] bit1;
        logic [XLEN-1:0] w;
        logic [1:0] pl;
        n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", XLEN'(trap_valid), 0);
        check("R1 reset cause", XLEN'(trap_cause), 0);
        check("R1 reset tval", trap_val, 0);
        check("R1 reset waiting", XLEN'(wfi_waiting), 0);
        rst_n = 1'b1;

        // Sweep V, privilege, trap bits, enable-bit pairs and all classes.
        for (int v = 0; v < 2; v++)
            for (int pi = 0; pi < 3; pi++)
                for (int ts = 0; ts < 2; ts++)
                    for (int tv = 0; tv < 2; tv++)
                        for (int mb = 0; mb < 2; mb++)
                            for (int hb = 0; hb < 2; hb++)
                                for (int c = 0; c < 9; c++) begin
                                    pl = (pi == 2) ? 2'b11 : 2'(pi);
                                    bit1 = NCTR'(1) << (n % NCTR);
                                    w = {16'(n), 16'h1073};
                                    issue(9'(1) << c, 1'b0, 1'(v), pl, 1'(ts), 1'(tv), 5'(n % NCTR),
                                          mb ? bit1 : ~bit1, hb ? bit1 : ~bit1, w,
                                          ref_cause(1'(v), pl, c, 1'(ts), 1'(tv), 1'(mb), 1'(hb)),
                                          class_tag(c, pl));
                                    n++;
                                end

        // R8: several flags, illegal wins over virtual.
        issue(9'b0_0000_0011, 0, 1, 2'b01, 0, 0, 5'd3, 32'h0, 32'h0, 32'hABCD_0001, 5'd2, "R8 ctr+hlv");
        issue(9'b0_1100_0000, 0, 1, 2'b00, 1, 1, 5'd0, 32'h0, 32'h0, 32'hABCD_0002, 5'd2, "R8 sret+sfence VU");
        issue(9'b1_0100_0010, 0, 1, 2'b01, 1, 1, 5'd0, '1, '1, 32'hABCD_0003, 5'd22, "R8 all virtual");
        go_idle();
        @(negedge clk);

        // R9: virtualized WFI times out exactly LIM edges after issue.
        issue('0, 1, 1, 2'b01, 0, 0, 0, '1, '1, 32'h1050_0073, 5'd0, "R9 issue");
        go_idle();
        for (int k = 1; k < LIM; k++) begin
            @(negedge clk);
            check("R9 no early trap", XLEN'(trap_valid), 0);
        end
        @(negedge clk);
        check("R9 timeout valid", XLEN'(trap_valid), 1);
        check("R9 timeout cause", XLEN'(trap_cause), 22);
        check("R9 timeout tval", trap_val, 32'h1050_0073);
        @(negedge clk);
        check("R9 one-cycle pulse", XLEN'(trap_valid), 0);
        check("R9 wait ended", XLEN'(wfi_waiting), 0);

        // R10: an interrupt ends the wait without a trap.
        issue('0, 1, 1, 2'b00, 0, 0, 0, '1, '1, 32'h1050_0073, 5'd0, "R10 issue");
        go_idle();
        check("R10 waiting", XLEN'(wfi_waiting), 1);
        irq_pending = 1'b1;
        @(negedge clk);
        check("R10 wait cleared", XLEN'(wfi_waiting), 0);
        irq_pending = 1'b0;
        for (int k = 0; k < 2 * LIM; k++) begin
            @(negedge clk);
            check("R10 no trap", XLEN'(trap_valid), 0);
        end

        // R11 and R12: unvirtualized WFI (also V=1 in M-mode) never times out.
        for (int m = 0; m < 2; m++) begin
            issue('0, 1, 1'(m), m ? 2'b11 : 2'b01, 0, 0, 0, '1, '1, 32'h1050_0073, 5'd0,
                  m ? "R12 wfi" : "R11 wfi");
            go_idle();
            for (int k = 0; k < 2 * LIM; k++) begin
                @(negedge clk);
                check(m ? "R12 no timeout" : "R11 no timeout", XLEN'(trap_valid), 0);
            end
            check(m ? "R12 still waiting" : "R11 still waiting", XLEN'(wfi_waiting), 1);
            irq_pending = 1'b1;
            @(negedge clk);
            irq_pending = 1'b0;
            check("R10 irq clears", XLEN'(wfi_waiting), 0);
        end

        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", XLEN'(exp_q.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule